// File: doc/BRIEF.md
# Trap and Interrupt Entry Guard

This block watches the processor while it enters a trap or an interrupt. Entry begins with a start strobe that names the kind of event. The processor then fetches the single instruction held at the vector location and executes it. Executing that instruction can include swapping the status words. Whatever that instruction starts afterwards is outside the window. While the window is open, the block checks the decoded class of the fetched instruction against what is legal for the current kind of entry. It also watches for processor faults. Either a forbidden class or a fault inside the window produces an instruction-exception request that carries a cause code.

The block has no part in opcode decoding or in building the vector address. It receives a class code from the decoder and reports back through a one-cycle request pulse and a cause field. A level output shows whether an entry window is currently open.

Top module: `trap_entry_guard`

## Requirements
- R1: While reset is asserted and right after it is released, `exc_req_o` is 0, `exc_cause_o` is 0 and `win_open_o` is 0.
- R2: When no window is open, a start strobe (`start_trap_i` or `start_irq_i`) sets `win_open_o` to 1 on the next cycle. If both strobes arrive together, the entry is handled as a trap.
- R3: Start strobes that arrive while a window is open are ignored. The kind of entry already recorded does not change.
- R4: In a trap entry, the only legal fetched classes are 1 (status exchange) and 2 (status push). Any other class on `fetch_cls_i` raises a request with cause 2 (illegal at vector) one cycle after the fetch.
- R5: In an interrupt entry, the legal classes are 1 and 2 plus 3, 4 and 5 (modify-and-test of a byte, halfword or word). Classes 0, 6 and 7 raise a request with cause 2.
- R6: After a legal fetch the window stays open until `exec_done_i`. It then closes on the next cycle without any request.
- R7: A fault while a window is open raises a request with cause 1 (fault during entry) on the next cycle. The window closes in the same cycle.
- R8: A fault while no window is open is ignored. This includes the cycle that carries the start strobe.
- R9: If an illegal fetch and a fault fall in the same cycle, the cause is 2.
- R10: `exc_req_o` lasts exactly one cycle. `exc_cause_o` is 0 whenever `exc_req_o` is 0.
- R11: `exec_done_i` while the window waits for its fetch is ignored. A fetch strobe after the vector instruction has already been accepted is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_trap_i | input | 1 | Trap entry begins |
| start_irq_i | input | 1 | Interrupt entry begins |
| fetch_vld_i | input | 1 | Vector instruction fetched this cycle |
| fetch_cls_i | input | CLS_W (3) | Decoded class of the fetched instruction |
| exec_done_i | input | 1 | Vector instruction finished executing |
| fault_i | input | 1 | Processor-detected fault |
| win_open_o | output | 1 | Entry window is open |
| exc_req_o | output | 1 | Instruction-exception request pulse |
| exc_cause_o | output | 2 | 0 none, 1 fault during entry, 2 illegal at vector |

## Verification
Two detections can land in the same cycle: a forbidden class arriving with its fetch strobe, and a fault. The bench drives both together in a trap window and in an interrupt window, and expects cause 2. It also pairs a legal fetch with a fault and expects cause 1. Completion together with a fault is covered as well, and it must still give cause 1. A long run with pseudo-random strobes then creates many more of these coincidences, and every cycle is compared against a behavioural model.

// File: rtl/teg_pkg.sv
package teg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2
  } teg_state_e;

  localparam int CLS_XCHG  = 1;
  localparam int CLS_PUSH  = 2;
  localparam int CLS_MODB  = 3;
  localparam int CLS_MODH  = 4;
  localparam int CLS_MODW  = 5;

  localparam logic [1:0] CAUSE_NONE    = 2'd0;
  localparam logic [1:0] CAUSE_FAULT   = 2'd1;
  localparam logic [1:0] CAUSE_ILLEGAL = 2'd2;
endpackage

// File: rtl/teg_legal_chk.sv
module teg_legal_chk
  import teg_pkg::*;
#(
  parameter int CLS_W = 3
) (
  input  logic             is_trap_i,
  input  logic [CLS_W-1:0] cls_i,
  output logic             legal_o
);
  localparam int NCLS = 1 << CLS_W;

  logic [NCLS-1:0] trap_ok;
  logic [NCLS-1:0] irq_ok;

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    assign trap_ok[g] = (g == CLS_XCHG) || (g == CLS_PUSH);
    assign irq_ok[g]  = trap_ok[g] || (g == CLS_MODB) ||
                        (g == CLS_MODH) || (g == CLS_MODW);
  end

  always_comb begin
    legal_o = is_trap_i ? trap_ok[cls_i] : irq_ok[cls_i];
  end
endmodule

// File: rtl/teg_seq_fsm.sv
module teg_seq_fsm
  import teg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_trap_i,
  input  logic start_irq_i,
  input  logic fetch_vld_i,
  input  logic legal_i,
  input  logic exec_done_i,
  input  logic fault_i,
  output logic is_trap_o,
  output logic open_o,
  output logic hit_illegal_o,
  output logic hit_fault_o
);
  teg_state_e state_q, state_d;
  logic       trap_q, trap_d;
  logic       kind_en;

  always_comb begin
    hit_illegal_o = (state_q == ST_FETCH) && fetch_vld_i && !legal_i;
    hit_fault_o   = (state_q != ST_IDLE) && fault_i;
    kind_en       = 1'b0;
    trap_d        = trap_q;
    state_d       = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_trap_i || start_irq_i) begin
          kind_en = 1'b1;
          trap_d  = start_trap_i;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (hit_illegal_o || hit_fault_o) state_d = ST_IDLE;
        else if (fetch_vld_i)             state_d = ST_EXEC;
      end
      ST_EXEC: begin
        if (hit_fault_o || exec_done_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      trap_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (kind_en) trap_q <= trap_d;
    end
  end

  assign is_trap_o = trap_q;
  assign open_o    = (state_q != ST_IDLE);
endmodule

// File: rtl/teg_exc_reg.sv
module teg_exc_reg
  import teg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_illegal_i,
  input  logic       hit_fault_i,
  output logic       req_o,
  output logic [1:0] cause_o
);
  logic       req_d;
  logic [1:0] cause_d;

  always_comb begin
    req_d   = hit_illegal_i || hit_fault_i;
    if (hit_illegal_i)    cause_d = CAUSE_ILLEGAL;
    else if (hit_fault_i) cause_d = CAUSE_FAULT;
    else                  cause_d = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o   <= 1'b0;
      cause_o <= CAUSE_NONE;
    end else begin
      req_o   <= req_d;
      cause_o <= cause_d;
    end
  end
endmodule

// File: rtl/trap_entry_guard.sv
module trap_entry_guard #(
  parameter int CLS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_trap_i,
  input  logic             start_irq_i,
  input  logic             fetch_vld_i,
  input  logic [CLS_W-1:0] fetch_cls_i,
  input  logic             exec_done_i,
  input  logic             fault_i,
  output logic             win_open_o,
  output logic             exc_req_o,
  output logic [1:0]       exc_cause_o
);
  logic is_trap;
  logic legal;
  logic hit_illegal;
  logic hit_fault;

  teg_legal_chk #(.CLS_W(CLS_W)) u_legal (
    .is_trap_i (is_trap),
    .cls_i     (fetch_cls_i),
    .legal_o   (legal)
  );

  teg_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_trap_i  (start_trap_i),
    .start_irq_i   (start_irq_i),
    .fetch_vld_i   (fetch_vld_i),
    .legal_i       (legal),
    .exec_done_i   (exec_done_i),
    .fault_i       (fault_i),
    .is_trap_o     (is_trap),
    .open_o        (win_open_o),
    .hit_illegal_o (hit_illegal),
    .hit_fault_o   (hit_fault)
  );

  teg_exc_reg u_exc (
    .clk           (clk),
    .rst_n         (rst_n),
    .hit_illegal_i (hit_illegal),
    .hit_fault_i   (hit_fault),
    .req_o         (exc_req_o),
    .cause_o       (exc_cause_o)
  );
endmodule

// File: rtl/teg_checker.sv
module teg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_trap_i,
  input logic       start_irq_i,
  input logic       fault_i,
  input logic       win_open_o,
  input logic       exc_req_o,
  input logic [1:0] exc_cause_o
);
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |=> !exc_req_o);

  p_cause_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req_o |-> (exc_cause_o == 2'd0));

  p_close_on_exc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |-> !win_open_o);

  p_fault_raises_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open_o && fault_i) |=> (exc_req_o && exc_cause_o != 2'd0));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open_o |=> !exc_req_o);

  p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open_o && (start_trap_i || start_irq_i)) |=> win_open_o);
endmodule

bind trap_entry_guard teg_checker u_teg_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_trap_i (start_trap_i),
  .start_irq_i  (start_irq_i),
  .fault_i      (fault_i),
  .win_open_o   (win_open_o),
  .exc_req_o    (exc_req_o),
  .exc_cause_o  (exc_cause_o)
);

// File: tb/test_trap_entry_guard.sv
`timescale 1ns/1ps
module test_trap_entry_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       st_trap = 1'b0, st_irq = 1'b0, fvld = 1'b0, done = 1'b0, flt = 1'b0;
  logic [2:0] cls = 3'd0;
  logic       open_w, req_w;
  logic [1:0] cause_w;

  int    checks = 0, fails = 0;
  string tag = "R1";
  bit    finished = 1'b0;

  // behavioural model: 0 idle, 1 waiting for fetch, 2 executing
  int m_st = 0, m_trap = 0, m_req = 0, m_cause = 0;

  always #2.5 clk = ~clk;

  trap_entry_guard i_trap_entry_guard (
    .clk(clk), .rst_n(rst_n), .start_trap_i(st_trap), .start_irq_i(st_irq),
    .fetch_vld_i(fvld), .fetch_cls_i(cls), .exec_done_i(done), .fault_i(flt),
    .win_open_o(open_w), .exc_req_o(req_w), .exc_cause_o(cause_w)
  );

  function automatic bit allowed(int trap, int c);
    if (c == 1 || c == 2) return 1'b1;
    if (trap == 0 && (c == 3 || c == 4 || c == 5)) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_trap = 0; m_req = 0; m_cause = 0;
    end else begin
      int bad, hurt;
      bad  = (m_st == 1 && fvld && !allowed(m_trap, int'(cls))) ? 1 : 0;
      hurt = (m_st != 0 && flt) ? 1 : 0;
      m_req   = (bad || hurt) ? 1 : 0;
      m_cause = bad ? 2 : (hurt ? 1 : 0);
      if (m_st == 0) begin
        if (st_trap || st_irq) begin m_st = 1; m_trap = st_trap ? 1 : 0; end
      end else if (bad || hurt) m_st = 0;
      else if (m_st == 1 && fvld) m_st = 2;
      else if (m_st == 2 && done) m_st = 0;
    end
  end

  task automatic compare();
    checks++;
    if (open_w !== (m_st != 0) || req_w !== m_req[0] || cause_w !== m_cause[1:0]) begin
      fails++;
      $display("FAIL %s: open/req/cause actual=%0b/%0b/%0d expected=%0b/%0b/%0d",
               tag, open_w, req_w, cause_w, (m_st != 0), m_req[0], m_cause);
    end
  endtask

  task automatic cyc(input bit t, input bit i, input bit fv, input int c,
                     input bit d, input bit f);
    @(negedge clk);
    compare();
    st_trap = t; st_irq = i; fvld = fv; cls = c[2:0]; done = d; flt = f;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1'b1;
    idle(2);
    // R2 R4 R6: legal trap entry, completion
    tag = "R2_R4_R6";
    cyc(1,0,0,0,0,0); cyc(0,0,1,1,0,0); cyc(0,0,0,0,1,0); idle(2);
    cyc(1,0,0,0,0,0); cyc(0,0,1,2,0,0); idle(2); cyc(0,0,0,0,1,0); idle(2);
    // R4 R10: illegal in trap
    tag = "R4_R10";
    cyc(1,0,0,0,0,0); cyc(0,0,1,5,0,0); idle(3);
    cyc(1,0,0,0,0,0); cyc(0,0,1,0,0,0); idle(3);
    // R5: interrupt entries
    tag = "R5";
    for (int c = 0; c < 8; c++) begin
      cyc(0,1,0,0,0,0); cyc(0,0,1,c,0,0); cyc(0,0,0,0,1,0); idle(2);
    end
    // R2: both strobes, trap wins
    tag = "R2";
    cyc(1,1,0,0,0,0); cyc(0,0,1,3,0,0); idle(3);
    // R3: second start ignored
    tag = "R3";
    cyc(1,0,0,0,0,0); cyc(0,1,0,0,0,0); cyc(0,0,1,4,0,0); idle(3);
    cyc(0,1,0,0,0,0); cyc(1,0,0,0,0,0); cyc(0,0,1,4,0,0); cyc(0,0,0,0,1,0); idle(2);
    // R8: fault outside window and on start cycle
    tag = "R8";
    cyc(0,0,0,0,0,1); idle(2); cyc(1,0,0,0,0,1); cyc(0,0,1,1,0,0); cyc(0,0,0,0,1,0); idle(2);
    // R7: fault while waiting, while executing, with completion
    tag = "R7";
    cyc(0,1,0,0,0,0); idle(1); cyc(0,0,0,0,0,1); idle(2);
    cyc(1,0,0,0,0,0); cyc(0,0,1,1,0,0); cyc(0,0,0,0,0,1); idle(2);
    cyc(1,0,0,0,0,0); cyc(0,0,1,2,0,0); cyc(0,0,0,0,1,1); idle(2);
    cyc(1,0,0,0,0,0); cyc(0,0,1,2,0,1); idle(2);
    // R9: illegal with fault in same cycle
    tag = "R9";
    cyc(1,0,0,0,0,0); cyc(0,0,1,4,0,1); idle(2);
    cyc(0,1,0,0,0,0); cyc(0,0,1,7,0,1); idle(2);
    // R11: early completion and late fetch ignored
    tag = "R11";
    cyc(1,0,0,0,0,0); cyc(0,0,0,0,1,0); cyc(0,0,1,1,0,0); cyc(0,0,1,6,0,0);
    idle(2); cyc(0,0,0,0,1,0); idle(2);
    // random coincidences against the model
    tag = "R9_R10_random";
    lf = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0] & lf[5], lf[1] & lf[6], lf[2], int'(lf[10:8]), lf[3] & lf[7], lf[4] & lf[11] & lf[12]);
    end
    idle(2);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule